// File: doc/BRIEF.md
# Mode-Configurable Dual-Port RAM

This block is a 256-bit memory with a write port and a read port that run independently. Each port has its own clock. A configuration input selects the shape of the array: 64 words of 4 bits, or 32 words of 8 bits. Both data buses are 8 bits wide and both addresses are 6 bits wide.

A write takes place on the active write-clock edge. Two parameters choose the active edge of each clock, rising or falling. A third parameter chooses the read path:
- **Registered:** the output register loads on an active read-clock edge while the read enable is high.
- **Flow-through:** the output follows the address and the contents of the memory combinationally.

The block is meant for small buffers, lookup tables and scratch storage next to logic that owns each port.

Top module: `dpram_cfg`

## Requirements
- R1: With `byte_mode`=1 the array holds 32 words of 8 bits. Address bit 5 is ignored on both ports, so addresses a and a+32 name the same word.
- R2: A write takes place only on an active write-clock edge where both `wr_en` and `blk_en` are 1. With either of them at 0 the stored contents do not change.
- R3: With `byte_mode`=0, `wr_data[3:0]` is stored in the 4-bit word at `wr_addr`. `rd_data[3:0]` carries the addressed word and `rd_data[7:4]` reads 0.
- R4: With `REG_READ`=1, `rd_data` keeps its value until an active read-clock edge where `rd_en`=1. After that edge it shows the word at `rd_addr`.
- R5: With `REG_READ`=0 and `rd_en`=1, `rd_data` follows changes of `rd_addr` without a read-clock edge. A write to the word being read also appears on `rd_data` without a read-clock edge.
- R6: With `REG_READ`=0 and `rd_en`=0, `rd_data` is 0.
- R7: `WR_FALL`=1 makes the falling edge of `wr_clk` the write edge, and `WR_FALL`=0 makes it the rising edge. `RD_FALL` selects the edge of `rd_clk` in the same way.
- R8: With `REG_READ`=1, a read and a write to the same word on the same active edge return the old contents. The next read returns the new contents.
- R9: While `rst_n`=0 the registered read output is 0, and it clears without waiting for a clock edge. The memory contents are not reset.
- R10: With `byte_mode`=0, the addresses a and a+32 (for a below 32) hold separate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock; active edge set by `WR_FALL` |
| rd_clk | input | 1 | Read port clock; active edge set by `RD_FALL` |
| rst_n | input | 1 | Active-low asynchronous reset of the read register |
| byte_mode | input | 1 | 1: 32x8 array, 0: 64x4 array |
| wr_data | input | 8 | Write data |
| wr_addr | input | 6 | Write address |
| wr_en | input | 1 | Write enable |
| blk_en | input | 1 | Block enable, ANDed with `wr_en` |
| rd_addr | input | 6 | Read address |
| rd_en | input | 1 | Read enable |
| rd_data | output | 8 | Read data |

## Verification
The bench builds two copies of the block that share all inputs and a single clock net:
- **Default copy:** registered read, both clocks active on the rising edge. It covers read-before-write on a shared edge, holding the output while `rd_en` is low, and clearing the output on reset.
- **Second copy:** flow-through read, write clock active on the falling edge. Writes therefore land half a cycle before the next rising edge. This lets the bench see the inverted write polarity and the clockless appearance of new data on the read port.

Random traffic runs in both array shapes against a bench model. Directed steps cover the aliasing in 8-bit mode and the separate upper and lower halves in 4-bit mode.

// File: rtl/dpram_cfg.sv
module dpram_cfg #(
  parameter int ADDR_W   = 6,
  parameter int NIB_W    = 4,
  parameter bit WR_FALL  = 1'b0,
  parameter bit RD_FALL  = 1'b0,
  parameter bit REG_READ = 1'b1
) (
  input  logic                 wr_clk,
  input  logic                 rd_clk,
  input  logic                 rst_n,
  input  logic                 byte_mode,
  input  logic [2*NIB_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_en,
  input  logic                 blk_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_en,
  output logic [2*NIB_W-1:0]   rd_data
);
  localparam int IDX_W  = ADDR_W - 1;
  localparam int BANK_D = 1 << IDX_W;
  localparam int BYTE_W = 2 * NIB_W;

  logic [NIB_W-1:0] bank_lo [BANK_D];
  logic [NIB_W-1:0] bank_hi [BANK_D];

  wire              wck  = wr_clk ^ WR_FALL;
  wire [IDX_W-1:0]  widx = wr_addr[IDX_W-1:0];
  wire [IDX_W-1:0]  ridx = rd_addr[IDX_W-1:0];

  always_ff @(posedge wck) begin
    if (wr_en && blk_en) begin
      if (byte_mode) begin
        bank_lo[widx] <= wr_data[NIB_W-1:0];
        bank_hi[widx] <= wr_data[BYTE_W-1:NIB_W];
      end else if (wr_addr[ADDR_W-1]) begin
        bank_hi[widx] <= wr_data[NIB_W-1:0];
      end else begin
        bank_lo[widx] <= wr_data[NIB_W-1:0];
      end
    end
  end

  wire [NIB_W-1:0]  rd_lo = bank_lo[ridx];
  wire [NIB_W-1:0]  rd_hi = bank_hi[ridx];
  wire [BYTE_W-1:0] rd_word = byte_mode ? {rd_hi, rd_lo}
                            : {{NIB_W{1'b0}}, (rd_addr[ADDR_W-1] ? rd_hi : rd_lo)};

  generate
    if (REG_READ) begin : g_reg
      wire rck = rd_clk ^ RD_FALL;
      logic [BYTE_W-1:0] q;
      always_ff @(posedge rck or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (rd_en) q <= rd_word;
      end
      assign rd_data = q;
    end else begin : g_flow
      logic unused_flow;
      assign unused_flow = rd_clk ^ rst_n;
      assign rd_data = rd_en ? rd_word : '0;
    end
  endgenerate
endmodule

// File: rtl/dpram_cfg_chk.sv
module dpram_cfg_chk #(
  parameter int ADDR_W   = 6,
  parameter int NIB_W    = 4,
  parameter bit WR_FALL  = 1'b0,
  parameter bit RD_FALL  = 1'b0,
  parameter bit REG_READ = 1'b1
) (
  input logic               wr_clk,
  input logic               rd_clk,
  input logic               rst_n,
  input logic               byte_mode,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               wr_en,
  input logic               blk_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               rd_en,
  input logic [2*NIB_W-1:0] rd_data
);
  wire rck = rd_clk ^ RD_FALL;
  wire wck = wr_clk ^ WR_FALL;

  logic [ADDR_W-1:0] unused_waddr;
  assign unused_waddr = wr_addr;

  p_upper_nibble_zero_r3: assert property (@(posedge rck) disable iff (!rst_n)
    (!byte_mode && rd_en) |=> (byte_mode || rd_data[2*NIB_W-1:NIB_W] == '0));

  p_sync_hold_r4: assert property (@(posedge rck) disable iff (!rst_n)
    (REG_READ && !rd_en) |=> $stable(rd_data));

  p_flow_idle_zero_r6: assert property (@(posedge rck) disable iff (!rst_n)
    (!REG_READ && !rd_en) |-> (rd_data == '0));

  p_write_gated_r2: assert property (@(posedge wck) disable iff (!rst_n)
    (!REG_READ && !(wr_en && blk_en)) |=>
      (!$stable(rd_addr) || !$stable(rd_en) || !$stable(byte_mode) || $stable(rd_data)));
endmodule

bind dpram_cfg dpram_cfg_chk #(
  .ADDR_W(ADDR_W), .NIB_W(NIB_W), .WR_FALL(WR_FALL), .RD_FALL(RD_FALL), .REG_READ(REG_READ)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .byte_mode(byte_mode),
  .wr_addr(wr_addr), .wr_en(wr_en), .blk_en(blk_en),
  .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/dpram_cfg_bench.sv
`timescale 1ns/1ps
module dpram_cfg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bm = 1'b1;
  logic [7:0] wd = '0;
  logic [5:0] wa = '0;
  logic       we = 1'b0;
  logic       be = 1'b0;
  logic [5:0] ra = '0;
  logic       re = 1'b0;
  logic [7:0] rd_a, rd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] model [64];
  logic [7:0] exp_a = '0;
  logic [7:0] exp_b = '0;

  always #2.5 clk = ~clk;

  dpram_cfg #(.REG_READ(1'b1), .WR_FALL(1'b0), .RD_FALL(1'b0)) u_dpram_cfg (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .byte_mode(bm),
    .wr_data(wd), .wr_addr(wa), .wr_en(we), .blk_en(be),
    .rd_addr(ra), .rd_en(re), .rd_data(rd_a));

  dpram_cfg #(.REG_READ(1'b0), .WR_FALL(1'b1), .RD_FALL(1'b0)) u_dpram_cfg_flow (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .byte_mode(bm),
    .wr_data(wd), .wr_addr(wa), .wr_en(we), .blk_en(be),
    .rd_addr(ra), .rd_en(re), .rd_data(rd_b));

  function automatic logic [7:0] rd_exp(input logic [5:0] a);
    if (bm) return {model[{1'b1, a[4:0]}], model[{1'b0, a[4:0]}]};
    return {4'h0, model[a]};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    if (tag == "") return;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input bit b, input logic [5:0] wad, input logic [7:0] wdat,
                      input bit r, input logic [5:0] rad, input string tag_a,
                      input string tag_b, input bit mid);
    logic [7:0] old_a;
    we = w; be = b; wa = wad; wd = wdat; re = r; ra = rad;
    old_a = exp_a;
    exp_a = r ? rd_exp(rad) : exp_a;
    if (w && b) begin
      if (bm) begin
        model[{1'b0, wad[4:0]}] = wdat[3:0];
        model[{1'b1, wad[4:0]}] = wdat[7:4];
      end else begin
        model[wad] = wdat[3:0];
      end
    end
    exp_b = r ? rd_exp(rad) : 8'h00;
    if (mid) begin
      #1.75;
      chk(rd_b, exp_b, "R7 falling write edge");
      chk(rd_a, old_a, "R7 no update on falling edge");
      #3.25;
    end else begin
      #5;
    end
    chk(rd_a, exp_a, tag_a);
    chk(rd_b, exp_b, tag_b);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1.25;
    chk(rd_a, 8'h00, "R9 reset value");
    chk(rd_b, 8'h00, "R6 idle output");
    rst_n = 1'b1;
    #5;

    bm = 1'b1;
    for (int i = 0; i < 32; i++) step(1, 1, 6'(i), 8'($urandom), 0, 0, "R4", "R6", 0);
    step(1, 1, 6'd5, 8'hA7, 1, 6'd37, "R1 alias old", "R1 alias new", 0);
    step(0, 0, 6'd0, 8'h00, 1, 6'd37, "R1 alias", "R1 alias", 0);
    step(1, 1, 6'd3, 8'h5C, 1, 6'd3, "R8 old contents", "R5", 0);
    step(0, 0, 6'd0, 8'h00, 1, 6'd3, "R8 new contents", "R5", 0);
    step(1, 0, 6'd3, 8'hFF, 0, 6'd9, "R4 hold", "R6", 0);
    step(0, 1, 6'd3, 8'hEE, 1, 6'd3, "R2 gated", "R2 gated", 0);
    step(1, 1, 6'd12, 8'h3D, 1, 6'd12, "R8", "R5", 1);
    ra = 6'd5; re = 1'b1; we = 1'b0;
    #0.5;
    chk(rd_b, rd_exp(6'd5), "R5 address follow");
    #4.5;
    exp_a = rd_exp(6'd5);
    chk(rd_a, exp_a, "R4 read edge");
    for (int i = 0; i < 250; i++)
      step(1'($urandom), 1'($urandom), 6'($urandom), 8'($urandom),
           1'($urandom), 6'($urandom), "R4", "R5", 0);

    we = 1'b0; re = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(rd_a, 8'h00, "R9 async clear");
    exp_a = 8'h00;
    #4;
    rst_n = 1'b1;
    #5;

    bm = 1'b0;
    for (int i = 0; i < 64; i++) step(1, 1, 6'(i), 8'($urandom), 0, 0, "R4", "R6", 0);
    step(1, 1, 6'd9, 8'hF1, 0, 6'd0, "R4", "R6", 0);
    step(1, 1, 6'd41, 8'hF6, 1, 6'd9, "R10 low half", "R10 low half", 0);
    step(0, 0, 6'd0, 8'h00, 1, 6'd41, "R10 high half", "R10 high half", 0);
    for (int i = 0; i < 250; i++)
      step(1'($urandom), 1'($urandom), 6'($urandom), 8'($urandom),
           1'($urandom), 6'($urandom), "R3", "R3", 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run=unfinished expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule